// File: doc/BRIEF.md
# Software Store/Recall Unlock Sequence Detector

This block monitors completed accesses on the address bus of a battery-free nonvolatile SRAM. It waits for software to read six particular addresses back to back. The first five addresses form a shared prefix. The sixth address decides which command follows: a STORE, which copies the SRAM into nonvolatile cells, or a RECALL, which copies the nonvolatile cells back into the SRAM. The selected command goes to the transfer engine as a one-cycle start pulse.

From the cycle that issues a command, the block raises a chip-disable output. That output stays high until the transfer engine has reported busy and then gone idle again. While it is high, and at any time the engine reports busy, accesses have no effect on the detector.

Writes never count as steps. A write, or a read at the wrong address, throws away any partly entered sequence. The one exception is a stray read at the first prefix address, which starts the sequence over at step one.

Top module: `swseq_detect`

## Requirements
- R1: While reset is high and in the first cycle after it, store_go, recall_go and chip_off are all 0.
- R2: Reads (acc_wr=0) at 0x0E38, 0x31C7, 0x03E0, 0x3C1F, 0x303F and then 0x0FC0, each presented with acc_vld=1, set store_go to 1 for exactly the one cycle after the clock edge that accepts the sixth read. recall_go stays 0.
- R3: The same five-read prefix followed by a read at 0x0C63 sets recall_go to 1 for exactly the one cycle after the sixth read. store_go stays 0.
- R4: An access with acc_wr=1 never counts as a step, and it returns a partly entered sequence to the start. No start pulse follows a write.
- R5: A read whose address differs from the next expected one returns the detector to the start. If that address is 0x0E38, the read counts as step one. A sixth read at any address other than 0x0FC0 or 0x0C63 issues no command.
- R6: An access presented while xfer_busy=1 is ignored. It neither advances nor resets the sequence.
- R7: chip_off rises in the same cycle as a start pulse. It stays 1 until xfer_busy has been seen at 1 and then at 0, and it falls in the cycle after xfer_busy is sampled at 0. Accesses made while chip_off=1 are ignored.
- R8: store_go and recall_go are never 1 together. Each stays high for a single cycle, and a completed sequence produces exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | One completed access is presented this cycle |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | ADDR_W | Address of the access |
| xfer_busy | input | 1 | Transfer engine is running a store or recall |
| store_go | output | 1 | One-cycle STORE start pulse |
| recall_go | output | 1 | One-cycle RECALL start pulse |
| chip_off | output | 1 | Memory accesses are disabled during the command |

## Verification
The bench builds the block with its default 15-bit address, so the codes it drives are the exact fixed unlock values. It sweeps every break-in point of the prefix, after one to five accepted steps. At each point it applies four kinds of disturbance: a write, a wrong read, a restart read at the first address, and an access during busy. It then finishes the sequence, which reaches every transition of the step counter, including the sixth-step branch. A command is issued in both directions. A model of the transfer engine pulses busy so that the release timing of chip_off, and the accesses dropped while it is high, can be checked at the ports.

// File: rtl/swseq_pkg.sv
package swseq_pkg;

    localparam int SEQ_LEN = 6;
    localparam int PRE_LEN = SEQ_LEN - 1;
    localparam int CODE_W  = 15;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t STORE_CODE  = 15'h0FC0;
    localparam code_t RECALL_CODE = 15'h0C63;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    typedef enum logic [1:0] {
        HOLD_IDLE = 2'd0,
        HOLD_WAIT = 2'd1,
        HOLD_RUN  = 2'd2
    } hold_e;

    typedef struct packed {
        logic take;
        logic is_wr;
    } qual_t;

    function automatic code_t prefix_code(input int idx);
        code_t c;
        case (idx)
            0:       c = 15'h0E38;
            1:       c = 15'h31C7;
            2:       c = 15'h03E0;
            3:       c = 15'h3C1F;
            4:       c = 15'h303F;
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/swseq_gate.sv
module swseq_gate
    import swseq_pkg::*;
(
    input  logic  acc_vld,
    input  logic  acc_wr,
    input  logic  xfer_busy,
    input  logic  chip_off,
    output qual_t qual
);

    always_comb begin
        qual.take  = acc_vld && !xfer_busy && !chip_off;
        qual.is_wr = acc_wr;
    end

endmodule

// File: rtl/swseq_matcher.sv
module swseq_matcher
    import swseq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  qual_t             qual,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              cmd_now,
    output logic              store_go,
    output logic              recall_go
);

    localparam int STEP_W = $clog2(SEQ_LEN);

    logic [STEP_W-1:0]  step_q, step_d;
    logic [PRE_LEN-1:0] hit_pre, step_sel;
    logic               hit_exp, hit_store, hit_recall;

    genvar g;
    generate
        for (g = 0; g < PRE_LEN; g++) begin : g_cmp
            assign hit_pre[g] = (addr == ADDR_W'(prefix_code(g)));
        end
    endgenerate

    assign hit_store  = (addr == ADDR_W'(STORE_CODE));
    assign hit_recall = (addr == ADDR_W'(RECALL_CODE));
    assign step_sel   = PRE_LEN'(1) << step_q;
    assign hit_exp    = |(hit_pre & step_sel);

    always_comb begin
        step_d  = step_q;
        cmd_now = CMD_NONE;
        if (qual.take) begin
            if (qual.is_wr) begin
                step_d = '0;
            end else if (step_q < STEP_W'(PRE_LEN)) begin
                if (hit_exp)         step_d = step_q + STEP_W'(1);
                else if (hit_pre[0]) step_d = STEP_W'(1);
                else                 step_d = '0;
            end else begin
                step_d = '0;
                if (hit_store)       cmd_now = CMD_STORE;
                else if (hit_recall) cmd_now = CMD_RECALL;
                else if (hit_pre[0]) step_d  = STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q    <= '0;
            store_go  <= 1'b0;
            recall_go <= 1'b0;
        end else begin
            step_q    <= step_d;
            store_go  <= (cmd_now == CMD_STORE);
            recall_go <= (cmd_now == CMD_RECALL);
        end
    end

    // R2
    step_range_chk: assert property (@(posedge clk) disable iff (rst)
        step_q <= STEP_W'(PRE_LEN));

    // R6
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !qual.take |=> $stable(step_q));

endmodule

// File: rtl/swseq_hold.sv
module swseq_hold
    import swseq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fire,
    input  logic xfer_busy,
    output logic chip_off
);

    hold_e hold_q, hold_d;

    always_comb begin
        hold_d = hold_q;
        case (hold_q)
            HOLD_IDLE: if (fire)       hold_d = HOLD_WAIT;
            HOLD_WAIT: if (xfer_busy)  hold_d = HOLD_RUN;
            HOLD_RUN:  if (!xfer_busy) hold_d = HOLD_IDLE;
            default:                   hold_d = HOLD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) hold_q <= HOLD_IDLE;
        else     hold_q <= hold_d;
    end

    assign chip_off = (hold_q != HOLD_IDLE);

    // R7
    wait_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q == HOLD_WAIT && !xfer_busy) |=> (hold_q == HOLD_WAIT));

    // R7
    no_refire_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q != HOLD_IDLE) |-> !fire);

endmodule

// File: rtl/swseq_detect.sv
module swseq_detect
    import swseq_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_vld,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              xfer_busy,
    output logic              store_go,
    output logic              recall_go,
    output logic              chip_off
);

    qual_t qual;
    cmd_e  cmd_now;

    swseq_gate u_gate (
        .acc_vld   (acc_vld),
        .acc_wr    (acc_wr),
        .xfer_busy (xfer_busy),
        .chip_off  (chip_off),
        .qual      (qual)
    );

    swseq_matcher #(.ADDR_W(ADDR_W)) u_match (
        .clk       (clk),
        .rst       (rst),
        .qual      (qual),
        .addr      (acc_addr),
        .cmd_now   (cmd_now),
        .store_go  (store_go),
        .recall_go (recall_go)
    );

    swseq_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .fire      (cmd_now != CMD_NONE),
        .xfer_busy (xfer_busy),
        .chip_off  (chip_off)
    );

    // R4
    wr_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && acc_wr) |=> (!store_go && !recall_go));

    // R6
    busy_no_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_vld && xfer_busy) |=> (!store_go && !recall_go));

    // R7
    pulse_off_chk: assert property (@(posedge clk) disable iff (rst)
        (store_go || recall_go) |-> chip_off);

    // R7
    release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_off) |-> !$past(xfer_busy));

    // R8
    excl_go_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({store_go, recall_go}));

    // R8
    store_once_chk: assert property (@(posedge clk) disable iff (rst)
        store_go |=> !store_go);

    // R8
    recall_once_chk: assert property (@(posedge clk) disable iff (rst)
        recall_go |=> !recall_go);

endmodule

// File: tb/sim_swseq_detect.sv
module sim_swseq_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_vld = 1'b0;
    logic        acc_wr = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        xfer_busy = 1'b0;
    logic        store_go, recall_go, chip_off;

    int total = 0;
    int bad = 0;

    localparam logic [14:0] C_STORE  = 15'h0FC0;
    localparam logic [14:0] C_RECALL = 15'h0C63;

    always #4 clk = ~clk;

    swseq_detect #(.ADDR_W(15)) u0 (
        .clk(clk), .rst(rst), .acc_vld(acc_vld), .acc_wr(acc_wr),
        .acc_addr(acc_addr), .xfer_busy(xfer_busy),
        .store_go(store_go), .recall_go(recall_go), .chip_off(chip_off)
    );

    function automatic logic [14:0] key(input int i);
        case (i)
            0: return 15'h0E38;
            1: return 15'h31C7;
            2: return 15'h03E0;
            3: return 15'h3C1F;
            default: return 15'h303F;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [14:0] a,
                          output logic s, output logic r);
        acc_vld  = 1'b1;
        acc_wr   = wr;
        acc_addr = a;
        @(posedge clk);
        @(negedge clk);
        acc_vld = 1'b0;
        acc_wr  = 1'b0;
        s = store_go;
        r = recall_go;
    endtask

    task automatic run_xfer(input string tag);
        check(chip_off == 1'b1, {tag, " R7 chip_off with pulse"}, chip_off, 1);
        @(negedge clk);
        check({store_go, recall_go} == 2'b00, {tag, " R8 single-cycle pulse"},
              {store_go, recall_go}, 0);
        check(chip_off == 1'b1, {tag, " R7 chip_off waiting"}, chip_off, 1);
        xfer_busy = 1'b1;
        repeat (3) @(negedge clk);
        check(chip_off == 1'b1, {tag, " R7 chip_off while busy"}, chip_off, 1);
        xfer_busy = 1'b0;
        @(negedge clk);
        check(chip_off == 1'b0, {tag, " R7 chip_off released"}, chip_off, 0);
    endtask

    // exp: 0 none, 1 store, 2 recall
    task automatic play(input int from, input logic [14:0] fin, input int exp,
                        input string tag);
        logic s, r;
        for (int i = from; i < 5; i++) begin
            access(1'b0, key(i), s, r);
            check({s, r} == 2'b00, {tag, " no pulse mid-sequence"}, {s, r}, 0);
        end
        access(1'b0, fin, s, r);
        check(s == (exp == 1), {tag, " store_go"}, s, int'(exp == 1));
        check(r == (exp == 2), {tag, " recall_go"}, r, int'(exp == 2));
        if (exp != 0) run_xfer(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic s, r;
        logic [14:0] fin;
        repeat (3) @(negedge clk);
        check({store_go, recall_go, chip_off} == 3'b000, "R1 outputs in reset",
              {store_go, recall_go, chip_off}, 0);
        rst = 1'b0;
        @(negedge clk);
        check({store_go, recall_go, chip_off} == 3'b000, "R1 outputs after reset",
              {store_go, recall_go, chip_off}, 0);

        play(0, C_STORE, 1, "R2 store");
        play(0, C_RECALL, 2, "R3 recall");

        // R4: the full sequence issued as writes
        for (int i = 0; i < 5; i++) access(1'b1, key(i), s, r);
        access(1'b1, C_STORE, s, r);
        check({s, r} == 2'b00, "R4 write sequence", {s, r}, 0);
        play(1, C_STORE, 0, "R4 after writes");

        // R7: an access made while chip_off is high is ignored
        for (int i = 0; i < 5; i++) access(1'b0, key(i), s, r);
        access(1'b0, C_STORE, s, r);
        check(s == 1'b1, "R7 setup store", s, 1);
        access(1'b0, key(0), s, r);
        check(chip_off == 1'b1, "R7 still off", chip_off, 1);
        xfer_busy = 1'b1;
        repeat (2) @(negedge clk);
        xfer_busy = 1'b0;
        @(negedge clk);
        check(chip_off == 1'b0, "R7 released", chip_off, 0);
        play(1, C_STORE, 0, "R7 ignored step one");

        // sweep over break-in point and disturbance kind
        for (int k = 1; k <= 5; k++) begin
            for (int d = 0; d < 4; d++) begin
                fin = (k % 2 == 0) ? C_STORE : C_RECALL;
                for (int i = 0; i < k; i++) access(1'b0, key(i), s, r);
                case (d)
                    0: begin
                        access(1'b1, (k < 5) ? key(k) : fin, s, r);
                        check({s, r} == 2'b00, "R4 write break", {s, r}, 0);
                        if (k < 5) play(k, fin, 0, "R4 after write break");
                        else begin
                            access(1'b0, fin, s, r);
                            check({s, r} == 2'b00, "R4 write before last", {s, r}, 0);
                        end
                    end
                    1: begin
                        access(1'b0, ((k < 5) ? key(k) : fin) ^ 15'h0001, s, r);
                        check({s, r} == 2'b00, "R5 wrong read", {s, r}, 0);
                        if (k < 5) play(k, fin, 0, "R5 after wrong read");
                        else begin
                            access(1'b0, fin, s, r);
                            check({s, r} == 2'b00, "R5 wrong sixth", {s, r}, 0);
                        end
                    end
                    2: begin
                        access(1'b0, key(0), s, r);
                        check({s, r} == 2'b00, "R5 restart read", {s, r}, 0);
                        play(1, fin, (fin == C_STORE) ? 1 : 2, "R5 restart completes");
                    end
                    default: begin
                        xfer_busy = 1'b1;
                        access(1'b0, (k < 5) ? key(k) : fin, s, r);
                        xfer_busy = 1'b0;
                        check({s, r} == 2'b00, "R6 busy access", {s, r}, 0);
                        check(chip_off == 1'b0, "R6 no disable on busy", chip_off, 0);
                        play(k, fin, (fin == C_STORE) ? 1 : 2, "R6 sequence kept");
                    end
                endcase
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule